// File: doc/BRIEF.md
# 8080-Style Parallel Bus Master

This block is the host side of a parallel display bus in the 8080 style. Each request from the host becomes one bus cycle. A write cycle drives the data bus and pulses the write strobe. A read cycle releases the data bus, pulses the read strobe and returns the sampled word together with a one-cycle valid flag. The word width is a parameter and may be anything from 8 to 18 bits. The pad cell that joins the output driver, its enable and the input path into one bidirectional pin sits outside this block.

Every request carries a data/command flag and a read/write flag. A read request also carries a kind: a register or ID read, or a frame-memory read. Each of the three cycle types has its own chip-select lead, its own strobe-low length and its own strobe-high length. All of these are counted in system clocks and set by parameters. The defaults suit a 125 MHz clock:

- Frame-memory reads are the slowest cycle by a wide margin.
- Writes use the shortest cycle.

A new request may be accepted during the last cycle of the current bus cycle. In that case chip select stays low and the next cycle starts at once, with its full lead, strobe and recovery phases.

Top module: `pbus_master`

## Requirements
- R1: While reset is held, and whenever the block is idle, `bus_cs_n`, `bus_wr_n` and `bus_rd_n` are 1, `bus_oe` is 0 and `rd_valid` is 0. A strobe is only ever low while `bus_cs_n` is 0.
- R2: A write takes WR_SU cycles with chip select low and both strobes high. Then `bus_wr_n` is low for exactly WR_LO cycles, then high for WR_HI cycles. `bus_oe` is 1 and `bus_dout` holds the request word for the whole cycle, including the cycle after the strobe rises.
- R3: `bus_dc` is 1 for a data request and 0 for a command request (`req_data` = 1 or 0). The value is present from the first cycle with chip select low until the cycle ends.
- R4: An ID read (`req_read` = 1, `req_fm` = 0) has a lead of ID_SU cycles, then `bus_rd_n` low for exactly ID_LO cycles, then high for ID_HI cycles.
- R5: A frame-memory read (`req_read` = 1, `req_fm` = 1) has a lead of FM_SU cycles, then `bus_rd_n` low for exactly FM_LO cycles, then high for FM_HI cycles.
- R6: `bus_din` is sampled on the clock edge that ends the last low cycle of `bus_rd_n`. `rd_data` then shows the sample, and `rd_valid` is 1 for exactly one cycle: the first cycle after the read strobe rises. A write never raises `rd_valid`.
- R7: `bus_oe` is 0 during every cycle of a read, from the first chip-select cycle through the last recovery cycle. It is therefore low before the read strobe falls and for at least one cycle after the strobe rises.
- R8: A request accepted in the last recovery cycle keeps `bus_cs_n` low with no high cycle in between. The next bus cycle still runs its full lead, strobe and recovery lengths.
- R9: `req_ready` is 1 only when the block is idle or in the last recovery cycle of a bus cycle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1.
- R10: Asserting `rst_n` low in the middle of a cycle returns the bus pins to their idle values at once, without waiting for a clock edge. After `rst_n` is released, the block accepts requests again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_fm | input | 1 | For reads: 1 = frame-memory read, 0 = ID/register read |
| req_data | input | 1 | 1 = data, 0 = command |
| req_wdata | input | DW | Write word |
| rd_valid | output | 1 | One-cycle pulse: read word available |
| rd_data | output | DW | Read word |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_dc | output | 1 | Data/command select |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dout | output | DW | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| bus_din | input | DW | Data bus input value |

## Verification
Counting from the clock edge that accepts a request, the timing is as follows:

- Chip select falls at that edge.
- The strobe falls after the cycle's lead length.
- The strobe rises after lead plus low length.
- `req_ready` returns in the last of lead plus low plus high cycles.
- `rd_valid` is due in cycle lead plus low plus one.

The bench steps through every cycle of a request at the falling clock edge and compares each pin with the phase that this count predicts. It counts the position of the valid pulse as part of the comparison. The bench's model of the display puts a running count of read-strobe low cycles on the input bus. The captured word must therefore equal the base value plus one less than the low length, which pins down the exact sampling edge.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_RD_ID = 2'd1,
    OP_RD_FM = 2'd2
  } op_e;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int min_of3(input int a, input int b, input int c);
    int m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

endpackage

// File: rtl/pbus_rst_sync.sv
module pbus_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pbus_len_sel.sv
// Picks the length (minus one) of a phase for a given cycle type.
module pbus_len_sel
  import pbus_pkg::*;
#(
  parameter int WR_SU = 2,
  parameter int WR_LO = 2,
  parameter int WR_HI = 3,
  parameter int ID_SU = 6,
  parameter int ID_LO = 6,
  parameter int ID_HI = 14,
  parameter int FM_SU = 45,
  parameter int FM_LO = 45,
  parameter int FM_HI = 12,
  parameter int CW    = 6
) (
  input  op_e           op,
  input  phase_e        ph,
  output logic [CW-1:0] len_m1
);
  always_comb begin
    len_m1 = '0;
    unique case (ph)
      PH_SETUP: begin
        unique case (op)
          OP_RD_ID: len_m1 = CW'(ID_SU - 1);
          OP_RD_FM: len_m1 = CW'(FM_SU - 1);
          default:  len_m1 = CW'(WR_SU - 1);
        endcase
      end
      PH_STROBE: begin
        unique case (op)
          OP_RD_ID: len_m1 = CW'(ID_LO - 1);
          OP_RD_FM: len_m1 = CW'(FM_LO - 1);
          default:  len_m1 = CW'(WR_LO - 1);
        endcase
      end
      PH_RECOVER: begin
        unique case (op)
          OP_RD_ID: len_m1 = CW'(ID_HI - 1);
          OP_RD_FM: len_m1 = CW'(FM_HI - 1);
          default:  len_m1 = CW'(WR_HI - 1);
        endcase
      end
      default: len_m1 = '0;
    endcase
  end
endmodule

// File: rtl/pbus_ctrl.sv
// Phase sequencer: phase register, down-counter, registered pin controls.
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int WR_SU = 2,
  parameter int WR_LO = 2,
  parameter int WR_HI = 3,
  parameter int ID_SU = 6,
  parameter int ID_LO = 6,
  parameter int ID_HI = 14,
  parameter int FM_SU = 45,
  parameter int FM_LO = 45,
  parameter int FM_HI = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_read,
  input  logic req_fm,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic cs_n,
  output logic wr_n,
  output logic rd_n,
  output logic oe
);
  localparam int LMAX = max_of3(max_of3(WR_SU, WR_LO, WR_HI),
                                max_of3(ID_SU, ID_LO, ID_HI),
                                max_of3(FM_SU, FM_LO, FM_HI));
  localparam int CW = (LMAX < 2) ? 1 : $clog2(LMAX);

  phase_e        ph_q, ph_n;
  op_e           op_q, op_n, req_op;
  logic [CW-1:0] cnt_q, cnt_n, len_m1;
  logic          last;
  logic          cs_n_n, wr_n_n, rd_n_n, oe_n;

  assign last      = (cnt_q == '0);
  assign req_op    = !req_read ? OP_WRITE : (req_fm ? OP_RD_FM : OP_RD_ID);
  assign req_ready = (ph_q == PH_IDLE) || ((ph_q == PH_RECOVER) && last);
  assign accept    = req_valid && req_ready;
  assign capture   = (ph_q == PH_STROBE) && last && (op_q != OP_WRITE);

  // next phase and cycle type
  always_comb begin
    ph_n = ph_q;
    op_n = op_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          ph_n = PH_SETUP;
          op_n = req_op;
        end
      end
      PH_SETUP:  if (last) ph_n = PH_STROBE;
      PH_STROBE: if (last) ph_n = PH_RECOVER;
      PH_RECOVER: begin
        if (last) begin
          if (req_valid) begin
            ph_n = PH_SETUP;
            op_n = req_op;
          end else begin
            ph_n = PH_IDLE;
          end
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  pbus_len_sel #(
    .WR_SU(WR_SU), .WR_LO(WR_LO), .WR_HI(WR_HI),
    .ID_SU(ID_SU), .ID_LO(ID_LO), .ID_HI(ID_HI),
    .FM_SU(FM_SU), .FM_LO(FM_LO), .FM_HI(FM_HI),
    .CW(CW)
  ) len_i (
    .op    (op_n),
    .ph    (ph_n),
    .len_m1(len_m1)
  );

  // next counter value
  always_comb begin
    cnt_n = cnt_q;
    if (ph_n != ph_q)  cnt_n = len_m1;
    else if (!last)    cnt_n = cnt_q - CW'(1);
  end

  // next pin values, decoded from the next phase so the pins are flops
  always_comb begin
    cs_n_n = (ph_n == PH_IDLE);
    wr_n_n = !((ph_n == PH_STROBE) && (op_n == OP_WRITE));
    rd_n_n = !((ph_n == PH_STROBE) && (op_n != OP_WRITE));
    oe_n   = (ph_n != PH_IDLE) && (op_n == OP_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      op_q  <= OP_WRITE;
      cnt_q <= '0;
      cs_n  <= 1'b1;
      wr_n  <= 1'b1;
      rd_n  <= 1'b1;
      oe    <= 1'b0;
    end else begin
      ph_q  <= ph_n;
      op_q  <= op_n;
      cnt_q <= cnt_n;
      cs_n  <= cs_n_n;
      wr_n  <= wr_n_n;
      rd_n  <= rd_n_n;
      oe    <= oe_n;
    end
  end
endmodule

// File: rtl/pbus_dpath.sv
// Write word / D-C holding register and read capture register.
module pbus_dpath #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_data,
  input  logic          capture,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dc,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_dout <= '0;
      bus_dc   <= 1'b0;
    end else if (accept) begin
      bus_dout <= req_wdata;
      bus_dc   <= req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (capture) rd_data <= bus_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= capture;
  end
endmodule

// File: rtl/pbus_master.sv
module pbus_master #(
  parameter int DW    = 16,
  parameter int WR_SU = 2,
  parameter int WR_LO = 2,
  parameter int WR_HI = 3,
  parameter int ID_SU = 6,
  parameter int ID_LO = 6,
  parameter int ID_HI = 14,
  parameter int FM_SU = 45,
  parameter int FM_LO = 45,
  parameter int FM_HI = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_read,
  input  logic          req_fm,
  input  logic          req_data,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          bus_cs_n,
  output logic          bus_dc,
  output logic          bus_wr_n,
  output logic          bus_rd_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din
);
  logic rst_sync_n;
  logic accept;
  logic capture;

  pbus_rst_sync rst_i (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(rst_sync_n)
  );

  pbus_ctrl #(
    .WR_SU(WR_SU), .WR_LO(WR_LO), .WR_HI(WR_HI),
    .ID_SU(ID_SU), .ID_LO(ID_LO), .ID_HI(ID_HI),
    .FM_SU(FM_SU), .FM_LO(FM_LO), .FM_HI(FM_HI)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_valid(req_valid),
    .req_read (req_read),
    .req_fm   (req_fm),
    .req_ready(req_ready),
    .accept   (accept),
    .capture  (capture),
    .cs_n     (bus_cs_n),
    .wr_n     (bus_wr_n),
    .rd_n     (bus_rd_n),
    .oe       (bus_oe)
  );

  pbus_dpath #(.DW(DW)) dpath_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .accept   (accept),
    .req_wdata(req_wdata),
    .req_data (req_data),
    .capture  (capture),
    .bus_din  (bus_din),
    .bus_dout (bus_dout),
    .bus_dc   (bus_dc),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk
  import pbus_pkg::*;
#(
  parameter int DW    = 16,
  parameter int WR_LO = 2,
  parameter int WR_HI = 3,
  parameter int ID_LO = 6,
  parameter int ID_HI = 14,
  parameter int FM_LO = 45,
  parameter int FM_HI = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wr_n,
  input logic          rd_n,
  input logic          oe,
  input logic          dc,
  input logic [DW-1:0] dout,
  input logic          rd_valid
);
  localparam int MIN_HI = min_of3(WR_HI, ID_HI, FM_HI);

  logic [7:0] wlo_q, rlo_q, gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlo_q <= '0;
      rlo_q <= '0;
      gap_q <= 8'hFF;
    end else begin
      wlo_q <= wr_n ? 8'd0 : ((wlo_q == 8'hFF) ? wlo_q : wlo_q + 8'd1);
      rlo_q <= rd_n ? 8'd0 : ((rlo_q == 8'hFF) ? rlo_q : rlo_q + 8'd1);
      if (!wr_n || !rd_n)     gap_q <= 8'd0;
      else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
    end
  end

  // R1
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> !cs_n);
  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));
  // R2
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (int'(wlo_q) == WR_LO));
  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (oe && $stable(dout) && $stable(dc)));
  // R3
  dc_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> $stable(dc));
  // R4 R5
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (int'(rlo_q) == ID_LO || int'(rlo_q) == FM_LO));
  // R6
  rdv_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(rd_n));
  // R7
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !oe);
  // R7
  rd_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |=> !oe);
  // R8
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_n) || $fell(rd_n)) |-> (int'(gap_q) >= MIN_HI));
endmodule

bind pbus_master pbus_master_chk #(
  .DW(DW), .WR_LO(WR_LO), .WR_HI(WR_HI),
  .ID_LO(ID_LO), .ID_HI(ID_HI), .FM_LO(FM_LO), .FM_HI(FM_HI)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .cs_n    (bus_cs_n),
  .wr_n    (bus_wr_n),
  .rd_n    (bus_rd_n),
  .oe      (bus_oe),
  .dc      (bus_dc),
  .dout    (bus_dout),
  .rd_valid(rd_valid)
);

// File: tb/pbus_master_tb.sv
`timescale 1ns/1ps
module pbus_master_tb_top;
  localparam int DW    = 16;
  localparam int WR_SU = 2;
  localparam int WR_LO = 2;
  localparam int WR_HI = 3;
  localparam int ID_SU = 6;
  localparam int ID_LO = 6;
  localparam int ID_HI = 14;
  localparam int FM_SU = 45;
  localparam int FM_LO = 45;
  localparam int FM_HI = 12;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_ready, req_read, req_fm, req_data;
  logic [DW-1:0] req_wdata;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          bus_cs_n, bus_dc, bus_wr_n, bus_rd_n, bus_oe;
  logic [DW-1:0] bus_dout, bus_din;

  int n_tests;
  int n_fail;

  // display model: input bus shows base plus count of low read-strobe cycles
  logic [DW-1:0] rd_base;
  logic [15:0]   low_run;
  assign bus_din = rd_base + DW'(low_run);

  always @(posedge clk) low_run <= bus_rd_n ? 16'd0 : low_run + 16'd1;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  pbus_master #(
    .DW(DW), .WR_SU(WR_SU), .WR_LO(WR_LO), .WR_HI(WR_HI),
    .ID_SU(ID_SU), .ID_LO(ID_LO), .ID_HI(ID_HI),
    .FM_SU(FM_SU), .FM_LO(FM_LO), .FM_HI(FM_HI)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_fm(req_fm), .req_data(req_data),
    .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .bus_cs_n(bus_cs_n), .bus_dc(bus_dc), .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .bus_din(bus_din)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic idle_pins(input string req);
    check(bus_cs_n === 1'b1 && bus_wr_n === 1'b1 && bus_rd_n === 1'b1 &&
          bus_oe === 1'b0 && rd_valid === 1'b0, req, "idle pins",
          {bus_cs_n, bus_wr_n, bus_rd_n, bus_oe, rd_valid}, 5'b11100);
  endtask

  // present a request at a falling edge; it is accepted at the next rising edge
  task automatic issue(input bit rd, input bit fm, input bit dc,
                       input logic [DW-1:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_fm = fm; req_data = dc; req_wdata = wd;
    check(req_ready === 1'b1, "R9", "ready when idle", req_ready, 1);
    @(posedge clk);
  endtask

  // walk one accepted bus cycle; optional next request in its last cycle
  task automatic walk(input bit rd, input bit fm, input bit dc,
                      input logic [DW-1:0] wd, input string treq,
                      input bit chain, input bit n_rd, input bit n_fm,
                      input bit n_dc, input logic [DW-1:0] n_wd);
    int su, lo, hi, tot;
    int e_tim, e_oe, e_dc, e_dat, e_rdy, v_cnt, v_k;
    logic [DW-1:0] v_dat;
    bit strobe;
    su = !rd ? WR_SU : (fm ? FM_SU : ID_SU);
    lo = !rd ? WR_LO : (fm ? FM_LO : ID_LO);
    hi = !rd ? WR_HI : (fm ? FM_HI : ID_HI);
    tot = su + lo + hi;
    e_tim = 0; e_oe = 0; e_dc = 0; e_dat = 0; e_rdy = 0; v_cnt = 0; v_k = 0;
    v_dat = '0;
    for (int k = 1; k <= tot; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      strobe = (k > su) && (k <= su + lo);
      if (bus_cs_n !== 1'b0 || bus_wr_n !== !(strobe && !rd) ||
          bus_rd_n !== !(strobe && rd)) e_tim++;
      if (bus_oe !== !rd) e_oe++;
      if (bus_dc !== dc) e_dc++;
      if (!rd && bus_dout !== wd) e_dat++;
      if (req_ready !== (k == tot)) e_rdy++;
      if (rd_valid === 1'b1) begin v_cnt++; v_k = k; v_dat = rd_data; end
      if (k == tot && chain) begin
        req_valid = 1'b1; req_read = n_rd; req_fm = n_fm;
        req_data = n_dc; req_wdata = n_wd;
      end
    end
    check(e_tim == 0, treq, "strobe/cs phase errors", e_tim, 0);
    check(e_oe == 0, rd ? "R7" : "R2", "driver enable errors", e_oe, 0);
    check(e_dc == 0, "R3", "d/c errors", e_dc, 0);
    if (!rd) check(e_dat == 0, "R2", "write word errors", e_dat, 0);
    check(e_rdy == 0, "R9", "ready timing errors", e_rdy, 0);
    if (rd) begin
      check(v_cnt == 1 && v_k == su + lo + 1, "R6", "valid pulse cycle",
            v_k, su + lo + 1);
      check(v_dat == rd_base + DW'(lo - 1), "R6", "captured word",
            int'(v_dat), int'(rd_base + DW'(lo - 1)));
    end else begin
      check(v_cnt == 0, "R6", "no valid on write", v_cnt, 0);
    end
    if (!chain) begin
      @(negedge clk);
      idle_pins("R1");
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    idle_pins("R1");
    check(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
  endtask

  task automatic t_write();
    issue(1'b0, 1'b0, 1'b1, 16'hA5C3);
    walk(1'b0, 1'b0, 1'b1, 16'hA5C3, "R2", 1'b0, 1'b0, 1'b0, 1'b0, '0);
    issue(1'b0, 1'b0, 1'b0, 16'h002C);
    walk(1'b0, 1'b0, 1'b0, 16'h002C, "R3", 1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_id_read();
    rd_base = 16'h1200;
    issue(1'b1, 1'b0, 1'b1, 16'hFFFF);
    walk(1'b1, 1'b0, 1'b1, 16'hFFFF, "R4", 1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_fm_read();
    rd_base = 16'h7700;
    issue(1'b1, 1'b1, 1'b1, 16'h0000);
    walk(1'b1, 1'b1, 1'b1, 16'h0000, "R5", 1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  // R8: write, then ID read, then write, chip select held low throughout
  task automatic t_chain();
    rd_base = 16'h0340;
    issue(1'b0, 1'b0, 1'b0, 16'h3C3C);
    walk(1'b0, 1'b0, 1'b0, 16'h3C3C, "R8", 1'b1, 1'b1, 1'b0, 1'b1, 16'h0000);
    walk(1'b1, 1'b0, 1'b1, 16'h0000, "R8", 1'b1, 1'b0, 1'b0, 1'b1, 16'h5AA5);
    walk(1'b0, 1'b0, 1'b1, 16'h5AA5, "R8", 1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_reset_mid();
    issue(1'b1, 1'b1, 1'b1, 16'h0000);
    repeat (FM_SU + 3) @(negedge clk);
    req_valid = 1'b0;
    check(bus_rd_n === 1'b0, "R10", "strobe low before reset", bus_rd_n, 0);
    rst_n = 1'b0;
    #1;
    idle_pins("R10");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_pins("R10");
    rd_base = 16'h0100;
    issue(1'b1, 1'b0, 1'b0, 16'h0000);
    walk(1'b1, 1'b0, 1'b0, 16'h0000, "R10", 1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_read = 1'b0; req_fm = 1'b0;
    req_data = 1'b0; req_wdata = '0; rd_base = '0;
    repeat (3) @(negedge clk);
    idle_pins("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write();
    t_id_read();
    t_fm_read();
    t_chain();
    t_reset_mid();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule